// File: doc/BRIEF.md
# Timer Counter Status Flags

This block is an up/down timer counter with an 8-bit status byte reporting the last count direction, counter overflow and counter underflow. A simple register port lets software read the status byte, clear flags and load or read the counter. Count-enable, direction and two mode inputs drive the counter. The phase-counting decoder and the complementary PWM engine are outside the block and appear only as mode inputs.

A parameter picks one of three channel flavours:
- **Basic:** no direction reporting and no underflow flag.
- **Phase:** direction reporting plus an underflow flag for phase counting.
- **Complementary PWM:** direction reporting, an extra overflow set path, and a clear path driven by an external transfer controller.

Software clears a flag in two steps. A read must first return the flag as 1. A later write of 0 to that bit then clears it. Each flag drives an interrupt request through its own enable input.

Top module: `tmr_stat_unit`

## Requirements
- R1: Status byte at address 0, read on `bus_rdata[7:0]` with upper bits 0: bit 7 direction, bit 6 constant 1, bit 5 underflow, bit 4 overflow, bits 3..0 read 0. After reset the byte reads 0xC0 and the counter reads 0.
- R2: A write to address 1 loads the counter, with priority over counting. While `cnt_en` is high the counter steps by +1 if `cnt_up` is 1 and by -1 otherwise. Address 1 reads the counter value.
- R3: On direction-reporting flavours, bit 7 holds the direction of the latest enabled count step (1 up, 0 down) and ignores status writes. On the basic flavour, bit 7 always reads 1.
- R4: The overflow flag sets when an up step wraps the counter from all ones to zero.
- R5: On the phase flavour, the underflow flag sets when a down step wraps the counter from zero to all ones while `mode_phase` is 1. No such wrap sets it while `mode_phase` is 0. On other flavours, bit 5 always reads 0.
- R6: A zero written to a set flag clears it only if an earlier status read returned that flag as 1. A zero write without such a read leaves the flag at 1.
- R7: Writing 1 to a flag bit has no effect. Once a flag clears, a new read that sees it at 1 is needed before the next zero write can clear it.
- R8: On the complementary PWM flavour, the overflow flag also sets on a down step from 1 to 0 while `mode_cpwm` is 1.
- R9: On the complementary PWM flavour, a high `ovf_ack` clears the overflow flag. Other flavours ignore `ovf_ack`.
- R10: When a set event and a clear request fall in the same cycle, the flag ends at 1.
- R11: `ovf_irq` equals overflow flag AND `ovf_ie`, and `unf_irq` equals underflow flag AND `unf_ie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Register read strobe; arms flags on a status read |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = status byte, 1 = counter |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data for the selected address (combinational) |
| cnt_en | input | 1 | Count step enable |
| cnt_up | input | 1 | Step direction, 1 = up |
| mode_phase | input | 1 | Phase counting mode active |
| mode_cpwm | input | 1 | Complementary PWM mode active |
| ovf_ack | input | 1 | Transfer-controller overflow clear |
| ovf_ie | input | 1 | Overflow interrupt enable |
| unf_ie | input | 1 | Underflow interrupt enable |
| ovf_irq | output | 1 | Overflow interrupt request |
| unf_irq | output | 1 | Underflow interrupt request |

## Verification
The bench drives all three flavours with the same stimulus and compares each against its own expected status byte.

- **Two-step clear:** a zero write with no prior read, a one written to a set flag, and a second zero write after a clear are all sent. A design that dropped or never cancelled the read arming would clear the flag on one of these.
- **Wrap paths:** the zero-to-all-ones wrap is tried with and without phase mode, and the one-to-zero step with complementary mode. A design that gated these events wrongly would raise a flag on the wrong flavour or mode.
- **Same-cycle conflict:** a clear and a wrap land in one cycle. A design that gave the clear priority would lose the event.

// File: rtl/tmr_stat_pkg.sv
package tmr_stat_pkg;

    typedef enum logic [1:0] {
        FLV_BASIC = 2'd0,
        FLV_PHASE = 2'd1,
        FLV_CPWM  = 2'd2
    } flavor_e;

    typedef struct packed {
        logic flag;
        logic armed;
    } flag_st_t;

    localparam int unsigned STAT_W   = 8;
    localparam int unsigned BIT_DIR  = 7;
    localparam int unsigned BIT_RSV  = 6;
    localparam int unsigned BIT_UNF  = 5;
    localparam int unsigned BIT_OVF  = 4;

endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          en_i,
    input  logic          up_i,
    output logic [CW-1:0] cnt_o,
    output logic          dir_o,
    output logic          wrap_up_o,
    output logic          wrap_dn_o,
    output logic          one_to_zero_o
);

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          dir_d, dir_q;
    logic          step;

    always_comb begin
        step          = en_i && !load_i;
        cnt_d         = cnt_q;
        dir_d         = dir_q;
        wrap_up_o     = step && up_i && (cnt_q == CNT_MAX);
        wrap_dn_o     = step && !up_i && (cnt_q == '0);
        one_to_zero_o = step && !up_i && (cnt_q == CNT_ONE);
        if (en_i) begin
            dir_d = up_i;
        end
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (en_i) begin
            cnt_d = up_i ? cnt_q + CNT_ONE : cnt_q - CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= 1'b1;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

    assign cnt_o = cnt_q;
    assign dir_o = dir_q;

    // R4
    wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i && up_i && cnt_q == CNT_MAX) |=> (cnt_q == '0));

    // R3
    dir_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> (dir_q == $past(up_i)));

endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell
    import tmr_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_hit_i,
    input  logic wr_hit_i,
    input  logic wbit_i,
    input  logic ack_i,
    output logic flag_o
);

    flag_st_t st_d, st_q;
    logic     clr_req;

    always_comb begin
        st_d    = st_q;
        clr_req = (wr_hit_i && !wbit_i && st_q.armed) || ack_i;
        if (rd_hit_i && st_q.flag) begin
            st_d.armed = 1'b1;
        end
        if (set_i) begin
            st_d.flag = 1'b1;
        end else if (clr_req) begin
            st_d.flag  = 1'b0;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> st_q.flag);

    // R6
    no_arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !st_q.armed && !ack_i) |=> st_q.flag);

endmodule

// File: rtl/tmr_stat_unit.sv
module tmr_stat_unit
    import tmr_stat_pkg::*;
#(
    parameter int unsigned CW     = 16,
    parameter flavor_e     FLAVOR = FLV_CPWM
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    input  logic          cnt_en,
    input  logic          cnt_up,
    input  logic          mode_phase,
    input  logic          mode_cpwm,
    input  logic          ovf_ack,
    input  logic          ovf_ie,
    input  logic          unf_ie,
    output logic          ovf_irq,
    output logic          unf_irq
);

    localparam bit LIVE_DIR  = (FLAVOR != FLV_BASIC);
    localparam bit LIVE_UNF  = (FLAVOR == FLV_PHASE);
    localparam bit LIVE_CPWM = (FLAVOR == FLV_CPWM);

    logic          rd_stat, wr_stat, wr_cnt;
    logic [CW-1:0] cnt;
    logic          dir, wrap_up, wrap_dn, one_to_zero;
    logic          ovf_set, ovf_clr_ack, ovf_flag, unf_flag;
    logic [STAT_W-1:0] stat;

    assign rd_stat = bus_rd && !bus_addr;
    assign wr_stat = bus_wr && !bus_addr;
    assign wr_cnt  = bus_wr && bus_addr;

    tmr_count_core #(.CW(CW)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (wr_cnt),
        .load_val_i   (bus_wdata),
        .en_i         (cnt_en),
        .up_i         (cnt_up),
        .cnt_o        (cnt),
        .dir_o        (dir),
        .wrap_up_o    (wrap_up),
        .wrap_dn_o    (wrap_dn),
        .one_to_zero_o(one_to_zero)
    );

    assign ovf_set     = wrap_up || (LIVE_CPWM && mode_cpwm && one_to_zero);
    assign ovf_clr_ack = LIVE_CPWM && ovf_ack;

    tmr_flag_cell u_ovf (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (ovf_set),
        .rd_hit_i(rd_stat),
        .wr_hit_i(wr_stat),
        .wbit_i  (bus_wdata[BIT_OVF]),
        .ack_i   (ovf_clr_ack),
        .flag_o  (ovf_flag)
    );

    generate
        if (LIVE_UNF) begin : g_unf
            tmr_flag_cell u_unf (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_i   (wrap_dn && mode_phase),
                .rd_hit_i(rd_stat),
                .wr_hit_i(wr_stat),
                .wbit_i  (bus_wdata[BIT_UNF]),
                .ack_i   (1'b0),
                .flag_o  (unf_flag)
            );
        end else begin : g_no_unf
            assign unf_flag = 1'b0;
        end
    endgenerate

    always_comb begin
        stat          = '0;
        stat[BIT_DIR] = LIVE_DIR ? dir : 1'b1;
        stat[BIT_RSV] = 1'b1;
        stat[BIT_UNF] = unf_flag;
        stat[BIT_OVF] = ovf_flag;
        bus_rdata     = bus_addr ? cnt : CW'(stat);
    end

    assign ovf_irq = ovf_flag && ovf_ie;
    assign unf_irq = unf_flag && unf_ie;

    // R5
    unf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unf_flag) |-> $past(mode_phase && cnt_en && !cnt_up));

    // R4
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(cnt_en));

endmodule

// File: tb/sim_tmr_stat_unit.sv
`timescale 1ns/1ps
module sim_tmr_stat_unit;
    import tmr_stat_pkg::*;

    localparam int CLK_P = 10;
    localparam int CW    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_rd = 0, bus_wr = 0, bus_addr = 0;
    logic [CW-1:0] bus_wdata = '0;
    logic cnt_en = 0, cnt_up = 1, mode_phase = 0, mode_cpwm = 0;
    logic ovf_ack = 0, ovf_ie = 1, unf_ie = 1;
    logic [CW-1:0] rd0, rd1, rd2;
    logic oi0, oi1, oi2, ui0, ui1, ui2;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    tmr_stat_unit #(.CW(CW), .FLAVOR(FLV_PHASE)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd0), .cnt_en(cnt_en), .cnt_up(cnt_up),
        .mode_phase(mode_phase), .mode_cpwm(mode_cpwm), .ovf_ack(ovf_ack),
        .ovf_ie(ovf_ie), .unf_ie(unf_ie), .ovf_irq(oi0), .unf_irq(ui0));
    tmr_stat_unit #(.CW(CW), .FLAVOR(FLV_BASIC)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd1), .cnt_en(cnt_en), .cnt_up(cnt_up),
        .mode_phase(mode_phase), .mode_cpwm(mode_cpwm), .ovf_ack(ovf_ack),
        .ovf_ie(ovf_ie), .unf_ie(unf_ie), .ovf_irq(oi1), .unf_irq(ui1));
    tmr_stat_unit #(.CW(CW), .FLAVOR(FLV_CPWM)) u2 (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd2), .cnt_en(cnt_en), .cnt_up(cnt_up),
        .mode_phase(mode_phase), .mode_cpwm(mode_cpwm), .ovf_ack(ovf_ack),
        .ovf_ie(ovf_ie), .unf_ie(unf_ie), .ovf_irq(oi2), .unf_irq(ui2));

    task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [CW-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        tick();
        bus_wr = 0; bus_addr = 0;
    endtask

    task automatic rd_stat();
        bus_addr = 0; bus_rd = 1;
        tick();
        bus_rd = 0;
    endtask

    task automatic step(input logic up, input int n);
        cnt_up = up; cnt_en = 1;
        repeat (n) tick();
        cnt_en = 0; cnt_up = 1;
    endtask

    task automatic peek_stat(input string req, input logic [7:0] e0, input logic [7:0] e1,
                             input logic [7:0] e2);
        bus_addr = 0; #1;
        chk({req, " u0"}, rd0, CW'(e0));
        chk({req, " u1"}, rd1, CW'(e1));
        chk({req, " u2"}, rd2, CW'(e2));
    endtask

    task automatic clean();
        rd_stat();
        wr(0, '0);
    endtask

    task automatic t_reset();
        peek_stat("R1 reset status", 8'hC0, 8'hC0, 8'hC0);
        bus_addr = 1; #1;
        chk("R1 reset counter", rd0, '0);
        bus_addr = 0;
    endtask

    task automatic t_ovf_basic();
        wr(1, 16'hFFFE);
        step(1, 2);
        bus_addr = 1; #1;
        chk("R2 counter after wrap", rd0, 16'h0000);
        peek_stat("R4 overflow set", 8'hD0, 8'hD0, 8'hD0);
        chk("R11 ovf_irq on", {15'd0, oi0}, 16'd1);
        ovf_ie = 0; #1;
        chk("R11 ovf_irq masked", {15'd0, oi1}, 16'd0);
        ovf_ie = 1;
        rd_stat();
        wr(0, 16'h0080);
        peek_stat("R6 R3 clear after read, dir unchanged", 8'hC0, 8'hC0, 8'hC0);
        chk("R11 ovf_irq off", {15'd0, oi2}, 16'd0);
    endtask

    task automatic t_no_arm();
        wr(1, 16'hFFFF);
        step(1, 1);
        wr(0, 16'h0000);
        #1 chk("R6 zero write without read", {15'd0, oi0}, 16'd1);
        rd_stat();
        wr(0, 16'h0010);
        #1 chk("R7 write one no effect", {15'd0, oi1}, 16'd1);
        wr(0, 16'h0000);
        #1 chk("R6 cleared after read", {15'd0, oi2}, 16'd0);
        wr(1, 16'hFFFF);
        step(1, 1);
        wr(0, 16'h0000);
        #1 chk("R7 arming cancelled by clear", {15'd0, oi0}, 16'd1);
        clean();
    endtask

    task automatic t_unf();
        mode_phase = 1;
        wr(1, 16'h0000);
        step(0, 1);
        bus_addr = 1; #1;
        chk("R2 down wrap counter", rd0, 16'hFFFF);
        peek_stat("R5 R3 underflow in phase mode", 8'h60, 8'hC0, 8'h40);
        chk("R11 unf_irq", {15'd0, ui0}, 16'd1);
        chk("R5 no unf_irq basic", {15'd0, ui1}, 16'd0);
        clean();
        peek_stat("R5 underflow cleared", 8'h40, 8'hC0, 8'h40);
        mode_phase = 0;
        wr(1, 16'h0000);
        step(0, 1);
        peek_stat("R5 no flag outside phase mode", 8'h40, 8'hC0, 8'h40);
    endtask

    task automatic t_cpwm();
        mode_cpwm = 1;
        wr(1, 16'h0001);
        step(0, 1);
        mode_cpwm = 0;
        peek_stat("R8 one-to-zero sets overflow", 8'h40, 8'hC0, 8'h50);
        ovf_ack = 1; tick(); ovf_ack = 0;
        peek_stat("R9 ack clears", 8'h40, 8'hC0, 8'h40);
        wr(1, 16'hFFFF);
        step(1, 1);
        ovf_ack = 1; tick(); ovf_ack = 0;
        peek_stat("R9 ack ignored elsewhere", 8'hD0, 8'hD0, 8'hC0);
        clean();
    endtask

    task automatic t_collide();
        wr(1, 16'hFFFF);
        step(1, 1);
        rd_stat();
        wr(1, 16'hFFFF);
        bus_addr = 0; bus_wdata = '0; bus_wr = 1; cnt_up = 1; cnt_en = 1;
        tick();
        bus_wr = 0; cnt_en = 0;
        peek_stat("R10 set wins over clear", 8'hD0, 8'hD0, 8'hD0);
        wr(0, '0);
        peek_stat("R10 later clear", 8'hC0, 8'hC0, 8'hC0);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_ovf_basic();
        t_no_arm();
        t_unf();
        t_cpwm();
        t_collide();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule